// File: doc/BRIEF.md
# Floating-Point Status and Trap Register

This block holds the status and control word of a floating-point unit. When an arithmetic unit finishes an operation, it strobes completion together with five raw exception indications: invalid operation, divide by zero, overflow, underflow and inexact. The block then rewrites the per-operation flag field with exactly those indications. It ORs any raised indication into a sticky cause field. When the accumulated cause overlaps a software-programmed enable field, it requests an exception carrying a fixed vector code.

Software loads the whole word through a write port. Only implemented bits are kept. The current word is always visible on a read port. Two control bits are decoded for the arithmetic units: a rounding selection (truncate or round-to-nearest-even) and a denormal flush control. Compare operations touch the word only when their result is unordered.

Register layout: bits 1:0 rounding field, bits 6:2 flags, bits 11:7 enables, bits 17:12 cause, bit 18 denormal flush, bits 21:19 spare implemented storage, bits 31:22 unimplemented (always zero). Within each five-bit group the order is, from low to high: inexact, underflow, overflow, divide-by-zero, invalid. Cause bit 17 is an unimplemented-operation cause. It is storage only.

Top module: `fpsr_unit`

## Requirements
- R1: After reset, rd_data reads 0x0004_0001 and trap_req and trap_vector are zero.
- R2: A cycle with wr_en high makes rd_data equal wr_data AND 0x003F_FFFF from the next cycle on.
- R3: round_to_zero is high exactly when rd_data[1:0] is 2'b01, and flush_denorm equals rd_data[18].
- R4: A counted completion (op_done high, and op_is_cmp low or cmp_unordered high) sets rd_data[6:2] to exc_in in the next cycle. exc_in[0]..exc_in[4] are inexact, underflow, overflow, divide-by-zero and invalid. Earlier flag values are discarded.
- R5: On a counted completion with exc_in non-zero, rd_data[16:12] becomes its old value OR exc_in. Bit 17, the enables, the rounding field and bits 21:18 keep their values.
- R6: On a counted completion with exc_in zero, the flags clear, all other bits keep their values, and no trap is requested.
- R7: trap_req is high for one cycle, the cycle after a counted completion, exactly when exc_in is non-zero and the updated cause bits 16:12 AND enable bits 11:7 are non-zero. trap_vector reads 0x120 while trap_req is high and zero otherwise. Cause bit 17 never requests a trap.
- R8: A completion with op_is_cmp high and cmp_unordered low changes nothing and requests no trap.
- R9: When wr_en and op_done are high in the same cycle, the write takes effect, the completion is discarded and no trap is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Value to write, masked to implemented bits |
| op_done | input | 1 | Operation completion strobe |
| op_is_cmp | input | 1 | Completing operation is a compare |
| cmp_unordered | input | 1 | Compare result was unordered |
| exc_in | input | 5 | Raw exception indications of the completing operation |
| rd_data | output | 32 | Current register value |
| round_to_zero | output | 1 | Truncating rounding selected |
| flush_denorm | output | 1 | Denormal flush selected |
| trap_req | output | 1 | One-cycle exception request |
| trap_vector | output | 12 | Exception vector code while trap_req is high |

## Verification
A wrong flag or cause bit held inside the block appears on rd_data in the cycle after the completion that produced it. A sticky cause bit that was lost or invented also changes the trap decision of the next completion that raises anything. A wrong enable comparison or a missed priority shows on trap_req and trap_vector one cycle after the strobe. A pulse that lingers shows one cycle later still. The sweep covers every exception pattern against every enable pattern, so a miswired bit position shows within the first few hundred operations.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
    localparam int REG_W    = 32;
    localparam int N_EXC    = 5;
    localparam int RM_LO    = 0;
    localparam int RM_W     = 2;
    localparam int FLAG_LO  = 2;
    localparam int EN_LO    = FLAG_LO + N_EXC;
    localparam int CAUSE_LO = EN_LO + N_EXC;
    localparam int CAUSE_W  = N_EXC + 1;
    localparam int DN_BIT   = CAUSE_LO + CAUSE_W;
    localparam int IMPL_W   = 22;
    localparam logic [REG_W-1:0] IMPL_MASK = REG_W'((64'd1 << IMPL_W) - 64'd1);
    localparam logic [RM_W-1:0]  RM_TRUNC  = 2'b01;

    typedef struct packed {
        logic [REG_W-1:0] csr;
        logic             trap;
    } fpsr_state_t;
endpackage

// File: rtl/fpsr_exc_merge.sv
module fpsr_exc_merge
    import fpsr_pkg::*;
(
    input  logic [REG_W-1:0] csr_cur,
    input  logic [N_EXC-1:0] exc,
    output logic [REG_W-1:0] csr_upd,
    output logic             trap_hit
);
    logic [N_EXC-1:0] cause_acc;
    logic [N_EXC-1:0] overlap;
    logic             any_exc;

    for (genvar i = 0; i < N_EXC; i++) begin : g_bit
        assign cause_acc[i] = csr_cur[CAUSE_LO + i] | exc[i];
        assign overlap[i]   = cause_acc[i] & csr_cur[EN_LO + i];
    end

    assign any_exc = |exc;

    always_comb begin
        csr_upd = csr_cur;
        csr_upd[FLAG_LO +: N_EXC] = exc;
        if (any_exc) begin
            csr_upd[CAUSE_LO +: N_EXC] = cause_acc;
        end
        trap_hit = any_exc && (|overlap);
    end
endmodule

// File: rtl/fpsr_mode_decode.sv
module fpsr_mode_decode
    import fpsr_pkg::*;
(
    input  logic [REG_W-1:0] csr,
    output logic             round_to_zero,
    output logic             flush_denorm
);
    always_comb begin
        round_to_zero = (csr[RM_LO +: RM_W] == RM_TRUNC);
        flush_denorm  = csr[DN_BIT];
    end
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
    import fpsr_pkg::*;
#(
    parameter int                VEC_W     = 12,
    parameter logic [VEC_W-1:0]  TRAP_CODE = 12'h120,
    parameter logic [REG_W-1:0]  RESET_VAL = 32'h0004_0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             op_done,
    input  logic             op_is_cmp,
    input  logic             cmp_unordered,
    input  logic [N_EXC-1:0] exc_in,
    output logic [REG_W-1:0] rd_data,
    output logic             round_to_zero,
    output logic             flush_denorm,
    output logic             trap_req,
    output logic [VEC_W-1:0] trap_vector
);
    localparam logic [REG_W-1:0] RESET_MASKED = RESET_VAL & IMPL_MASK;

    fpsr_state_t      st_d, st_q;
    logic [REG_W-1:0] csr_upd;
    logic             trap_hit;
    logic             op_live;

    fpsr_exc_merge u_merge (
        .csr_cur  (st_q.csr),
        .exc      (exc_in),
        .csr_upd  (csr_upd),
        .trap_hit (trap_hit)
    );

    fpsr_mode_decode u_mode (
        .csr           (st_q.csr),
        .round_to_zero (round_to_zero),
        .flush_denorm  (flush_denorm)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        op_live   = op_done && (!op_is_cmp || cmp_unordered);
        if (wr_en) begin
            st_d.csr = wr_data & IMPL_MASK;
        end else if (op_live) begin
            st_d.csr  = csr_upd;
            st_d.trap = trap_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.csr  <= RESET_MASKED;
            st_q.trap <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data     = st_q.csr;
    assign trap_req    = st_q.trap;
    assign trap_vector = st_q.trap ? TRAP_CODE : '0;
endmodule

// File: rtl/fpsr_unit_chk.sv
module fpsr_unit_chk
    import fpsr_pkg::*;
#(
    parameter int VEC_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             op_done,
    input logic             op_is_cmp,
    input logic             cmp_unordered,
    input logic [N_EXC-1:0] exc_in,
    input logic [REG_W-1:0] rd_data,
    input logic             trap_req,
    input logic [VEC_W-1:0] trap_vector
);
    AST_WRITE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == ($past(wr_data) & IMPL_MASK)); // R2
    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !op_is_cmp && !wr_en) |=> rd_data[FLAG_LO +: N_EXC] == $past(exc_in)); // R4
    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !wr_en) |=> (rd_data[CAUSE_LO +: CAUSE_W] & $past(rd_data[CAUSE_LO +: CAUSE_W])) == $past(rd_data[CAUSE_LO +: CAUSE_W])); // R5
    AST_QUIET_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !wr_en && exc_in == '0) |=> !trap_req); // R6
    AST_VECTOR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_vector == 12'h120); // R7
    AST_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_done && !wr_en) |=> !trap_req && $stable(rd_data)); // R7
    AST_CMP_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_is_cmp && !cmp_unordered && !wr_en) |=> $stable(rd_data) && !trap_req); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !trap_req); // R9
endmodule

bind fpsr_unit fpsr_unit_chk #(.VEC_W(VEC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .op_done       (op_done),
    .op_is_cmp     (op_is_cmp),
    .cmp_unordered (cmp_unordered),
    .exc_in        (exc_in),
    .rd_data       (rd_data),
    .trap_req      (trap_req),
    .trap_vector   (trap_vector)
);

// File: tb/fpsr_unit_tb.sv
`timescale 1ns/1ps
module fpsr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_done = 1'b0;
    logic        op_is_cmp = 1'b0;
    logic        cmp_unordered = 1'b0;
    logic [4:0]  exc_in = '0;
    logic [31:0] rd_data;
    logic        round_to_zero, flush_denorm, trap_req;
    logic [11:0] trap_vector;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model;
    bit finished = 1'b0;

    localparam logic [31:0] MASK = 32'h003F_FFFF;

    fpsr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_done(op_done), .op_is_cmp(op_is_cmp), .cmp_unordered(cmp_unordered),
        .exc_in(exc_in), .rd_data(rd_data), .round_to_zero(round_to_zero),
        .flush_denorm(flush_denorm), .trap_req(trap_req), .trap_vector(trap_vector)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Expected next word and trap for a counted completion, from R4..R7.
    task automatic predict(input logic [31:0] cur, input logic [4:0] e,
                           output logic [31:0] nx, output bit tr);
        logic [4:0] cause;
        nx = (cur & ~(32'h1F << 2)) | (32'(e) << 2);
        cause = cur[16:12] | e;
        if (e != 0) nx = (nx & ~(32'h1F << 12)) | (32'(cause) << 12);
        tr = (e != 0) && ((cause & cur[11:7]) != 0);
    endtask

    task automatic check_modes(input string req);
        chk(round_to_zero == (model[1:0] == 2'b01), req, 32'(round_to_zero), 32'(model[1:0] == 2'b01));
        chk(flush_denorm == model[18], req, 32'(flush_denorm), 32'(model[18]));
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        chk(trap_req == 1'b0, "R7 pulse ends", 32'(trap_req), 0);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        model = v & MASK;
        chk(rd_data == model, "R2 masked write", rd_data, model);
        check_modes("R3 mode decode");
    endtask

    task automatic op(input logic [4:0] e, input bit cmp, input bit unord, input string req);
        logic [31:0] nx;
        bit tr;
        @(negedge clk);
        chk(trap_req == 1'b0, "R7 pulse ends", 32'(trap_req), 0);
        op_done = 1'b1; op_is_cmp = cmp; cmp_unordered = unord; exc_in = e;
        predict(model, e, nx, tr);
        if (cmp && !unord) begin nx = model; tr = 1'b0; end
        @(negedge clk);
        op_done = 1'b0; op_is_cmp = 1'b0; cmp_unordered = 1'b0; exc_in = '0;
        chk(rd_data == nx, req, rd_data, nx);
        chk(trap_req == tr, {req, " R7 trap"}, 32'(trap_req), 32'(tr));
        chk(trap_vector == (tr ? 12'h120 : 12'h000), {req, " R7 vector"}, 32'(trap_vector), tr ? 32'h120 : 32'h0);
        model = nx;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        model = 32'h0004_0001;
        chk(rd_data == model, "R1 reset word", rd_data, model);
        chk(trap_req == 1'b0 && trap_vector == 0, "R1 no trap", 32'(trap_req), 0);
        rst_n = 1'b1;
        check_modes("R1 R3 reset modes");

        // Every enable pattern against every exception pattern.
        for (int en = 0; en < 32; en++) begin
            for (int e = 0; e < 32; e++) begin
                logic [31:0] v;
                v = (32'(en) << 7) | 32'(en[1:0]) | (32'(en[2]) << 18) | (32'(e) << 2)
                    | ((e[0]) ? 32'hFFC0_0000 : 32'h0);
                wr(v);
                op(5'(e), 1'b0, 1'b0, "R4 R5 R6 sweep");
            end
        end

        // Cause accumulates, flags do not; zero exc clears flags only.
        wr(32'h0000_0000);
        op(5'h01, 1'b0, 1'b0, "R4 R5 accumulate");
        op(5'h02, 1'b0, 1'b0, "R4 R5 accumulate");
        op(5'h00, 1'b0, 1'b0, "R6 quiet completion");
        chk(rd_data[16:12] == 5'h03, "R5 sticky cause", 32'(rd_data[16:12]), 32'h3);

        // Stale cause with matching enable traps on an unrelated exception.
        wr((32'h1 << 12) | (32'h1 << 7));
        op(5'h02, 1'b0, 1'b0, "R7 sticky overlap");
        op(5'h00, 1'b0, 1'b0, "R6 no trap when quiet");

        // Back-to-back trapping completions.
        wr(32'h1F << 7);
        op(5'h10, 1'b0, 1'b0, "R7 first trap");
        op(5'h08, 1'b0, 1'b0, "R7 second trap");

        // Unimplemented-operation cause bit never traps and stays put.
        wr((32'h1 << 17) | (32'h1F << 7) | (32'h1 << 18));
        op(5'h00, 1'b0, 1'b0, "R7 bit17 no trap");
        chk(rd_data[17] == 1'b1, "R5 bit17 kept", 32'(rd_data[17]), 1);

        // Compare: ordered ignored, unordered counted.
        wr((32'h1F << 7) | (32'h15 << 2));
        op(5'h1F, 1'b1, 1'b0, "R8 ordered compare ignored");
        op(5'h01, 1'b1, 1'b1, "R8 unordered compare");

        // Write and completion together: write wins.
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'hFFFF_FF82;
        op_done = 1'b1; exc_in = 5'h1F;
        @(negedge clk);
        wr_en = 1'b0; op_done = 1'b0; exc_in = '0;
        model = 32'hFFFF_FF82 & MASK;
        chk(rd_data == model, "R9 write wins", rd_data, model);
        chk(trap_req == 1'b0, "R9 no trap", 32'(trap_req), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule